// File: doc/BRIEF.md
# Serial Receive Framer with Header Check

This block sits between a despreader and the MAC. It takes demodulated bits, each marked by a one-cycle valid strobe, and turns them into the serial receive interface: a data line, a bit clock and a frame-ready envelope. It hunts for the 16-bit start-frame delimiter. Once the delimiter is found, it raises the envelope and passes each header and payload bit to the MAC, one bit-clock pulse per bit.

The header is 48 bits, in this order: an 8-bit signal field, an 8-bit service field, a 16-bit length field and a 16-bit CRC. The block checks the CRC and the signal field as the header arrives. While the CRC bits go by, the bit clock stays idle. A header fault drops the envelope. So does loss of the receive enable. After either, the block goes back to hunting for the delimiter.

Incoming valid strobes must be at least two clock cycles apart, so that each bit-clock pulse can finish.

Top module: `rx_framer`

## Requirements
- R1: After reset, `data_rdy_o` is 0, `ser_data_o` is 0 and `ser_clk_o` sits at its idle level (0 when `clk_inv_i` is 0).
- R2: The delimiter is 16'hF3A0, received least significant bit first. `data_rdy_o` rises on the clock after the valid strobe of the last delimiter bit, and not earlier.
- R3: `ser_clk_o` makes no pulse while `data_rdy_o` is low, including while the block is hunting for the delimiter.
- R4: For every bit passed on, `ser_data_o` takes the bit on the clock that accepts it, and `ser_clk_o` goes high for exactly one cycle on the following clock. Bits leave in the order they arrived, so the least significant bit of each field goes first.
- R5: During the 16 CRC bits (header bits 32 to 47), `ser_clk_o` makes no pulse. With a good CRC, `data_rdy_o` stays high and the payload bits that follow are clocked out again.
- R6: The CRC covers header bits 0 to 31 in arrival order. It uses x^16+x^12+x^5+1, is preset to 16'hFFFF and is inverted before comparison. Its bit 15 is received first. On a mismatch, `data_rdy_o` falls on the clock after the last CRC bit, and no further bits are clocked out.
- R7: The 8-bit signal field is valid only if it is 8'h0A, 8'h14, 8'h37 or 8'h6E. Any other value makes `data_rdy_o` fall on the clock after the eighth header bit, and that bit gets no clock pulse.
- R8: When `rx_en_i` is low, `data_rdy_o` is 0 from the next clock, and valid bits are ignored. A delimiter received partly while disabled and partly after enabling causes no detection.
- R9: When `clk_inv_i` is 1, `ser_clk_o` is the complement of its normal waveform: idle level 1, and each bit marked by a low pulse.
- R10: After a frame is aborted, the delimiter search restarts at once, without the receive enable having to toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_en_i | input | 1 | Receive enable; low puts the block in standby |
| rx_bit_i | input | 1 | Demodulated bit |
| rx_bit_vld_i | input | 1 | One-cycle strobe marking `rx_bit_i` as valid |
| clk_inv_i | input | 1 | Inverts the polarity of the bit clock |
| ser_data_o | output | 1 | Serial data toward the MAC |
| ser_clk_o | output | 1 | Bit clock toward the MAC |
| data_rdy_o | output | 1 | Frame envelope, high from delimiter detection until the frame ends |

## Verification
The bench goes after the CRC window, the point of abort, and enable and polarity changes.

- **CRC window.** A design that clocked out the CRC bits would pop unexpected entries from the scoreboard. One that stayed silent past the window would leave payload bits unclaimed.
- **Signal field.** A corrupted CRC and an unsupported signal value are each placed at their exact bit. A design that checked late, or that still pulsed the offending bit, would show the envelope high one sample too long or an extra pulse.
- **Split delimiter.** A delimiter is split across a disabled period. A design that kept shifting while in standby would detect it.
- **Restart and polarity.** Back-to-back frames after an abort catch a search that fails to restart. An inverted-polarity frame catches a clock that is only inverted while idle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int             SFD_W     = 16;
  localparam logic [15:0]    SFD_PAT   = 16'hF3A0;
  localparam int             SIG_W     = 8;
  localparam int             SVC_W     = 8;
  localparam int             LEN_W     = 16;
  localparam int             CRC_W     = 16;
  localparam int             DATA_BITS = SIG_W + SVC_W + LEN_W;
  localparam logic [15:0]    CRC_POLY  = 16'h1021;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

  function automatic logic rate_ok(input logic [SIG_W-1:0] s);
    case (s)
      8'h0A, 8'h14, 8'h37, 8'h6E: return 1'b1;
      default:                    return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/rxf_sfd_search.sv
module rxf_sfd_search #(
  parameter int          W   = 16,
  parameter logic [15:0] PAT = 16'hF3A0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic vld_i,
  input  logic bit_i,
  input  logic frame_i,
  output logic hit_o
);
  logic [W-1:0] sh_q, sh_nxt;
  logic         hunt;

  assign hunt   = en_i & vld_i & ~frame_i;
  assign sh_nxt = {bit_i, sh_q[W-1:1]};   // first-received bit ends up at bit 0
  assign hit_o  = hunt & (sh_nxt == PAT[W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sh_q <= '0;
    else if (!en_i || frame_i)  sh_q <= '0;
    else if (hunt)              sh_q <= sh_nxt;
  end
endmodule

// File: rtl/rxf_hdr_check.sv
module rxf_hdr_check
  import rxf_pkg::*;
#(
  parameter int DBITS = DATA_BITS,
  parameter int CBITS = CRC_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic vld_i,
  input  logic bit_i,
  input  logic sfd_hit_i,
  output logic frame_o,
  output logic deliver_o,
  output logic crc_phase_o,
  output logic hdr_err_o
);
  localparam int TOT = DBITS + CBITS;
  localparam int CW  = $clog2(TOT + 1);

  logic             frame_q, bad_q;
  logic [CW-1:0]    cnt_q;
  logic [CBITS-1:0] crc_q;
  logic [SIG_W-1:0] sig_q, sig_nxt;
  logic             take, in_data, in_crc, sig_last, crc_last, bit_bad, sig_err, crc_err;

  assign take     = frame_q & en_i & vld_i;
  assign in_data  = cnt_q < CW'(DBITS);
  assign in_crc   = (cnt_q >= CW'(DBITS)) && (cnt_q < CW'(TOT));
  assign sig_nxt  = {bit_i, sig_q[SIG_W-1:1]};
  assign sig_last = cnt_q == CW'(SIG_W - 1);
  assign crc_last = cnt_q == CW'(TOT - 1);
  assign bit_bad  = bit_i != ~crc_q[CBITS-1];
  assign sig_err  = take & sig_last & ~rate_ok(sig_nxt);
  assign crc_err  = take & crc_last & (bad_q | bit_bad);

  assign hdr_err_o   = sig_err | crc_err;
  assign frame_o     = frame_q;
  assign crc_phase_o = frame_q & in_crc;
  assign deliver_o   = take & ~in_crc & ~hdr_err_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= 1'b0;
      cnt_q   <= '0;
      crc_q   <= '1;
      sig_q   <= '0;
      bad_q   <= 1'b0;
    end else if (!en_i) begin
      frame_q <= 1'b0;
    end else if (!frame_q) begin
      if (sfd_hit_i) begin
        frame_q <= 1'b1;
        cnt_q   <= '0;
        crc_q   <= '1;
        sig_q   <= '0;
        bad_q   <= 1'b0;
      end
    end else if (take) begin
      if (hdr_err_o) begin
        frame_q <= 1'b0;
      end else begin
        if (cnt_q != CW'(TOT)) cnt_q <= cnt_q + 1'b1;
        if (cnt_q < CW'(SIG_W)) sig_q <= sig_nxt;
        if (in_data) crc_q <= crc_step(crc_q, bit_i);
        if (in_crc) begin
          bad_q <= bad_q | bit_bad;
          crc_q <= {crc_q[CBITS-2:0], 1'b0};  // expose next expected bit at msb
        end
      end
    end
  end

  AST_ERR_NOT_DELIVERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_err_o |=> !frame_q);  // R6
endmodule

// File: rtl/rxf_ser_out.sv
module rxf_ser_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic frame_i,
  input  logic deliver_i,
  input  logic bit_i,
  input  logic inv_i,
  output logic data_o,
  output logic clk_o,
  output logic clk_raw_o
);
  logic data_q, dly_q, pulse_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q  <= 1'b0;
      dly_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (deliver_i)              data_q <= bit_i;
      else if (!en_i || !frame_i) data_q <= 1'b0;
      dly_q   <= deliver_i;
      pulse_q <= dly_q & en_i & frame_i;  // rising edge one clock after data settles
    end
  end

  assign data_o    = data_q;
  assign clk_raw_o = pulse_q;
  assign clk_o     = pulse_q ^ inv_i;

  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_q |=> !pulse_q);  // R4
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import rxf_pkg::*;
#(
  parameter int          SFD_BITS = SFD_W,
  parameter logic [15:0] SFD_VAL  = SFD_PAT,
  parameter int          HDR_DATA = DATA_BITS,
  parameter int          HDR_CRC  = CRC_W
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_en_i,
  input  logic rx_bit_i,
  input  logic rx_bit_vld_i,
  input  logic clk_inv_i,
  output logic ser_data_o,
  output logic ser_clk_o,
  output logic data_rdy_o
);
  logic sfd_hit, frame, deliver, crc_phase, hdr_err, clk_raw;

  rxf_sfd_search #(.W(SFD_BITS), .PAT(SFD_VAL)) u_sfd (
    .clk_i, .rst_ni, .en_i(rx_en_i), .vld_i(rx_bit_vld_i), .bit_i(rx_bit_i),
    .frame_i(frame), .hit_o(sfd_hit)
  );

  rxf_hdr_check #(.DBITS(HDR_DATA), .CBITS(HDR_CRC)) u_hdr (
    .clk_i, .rst_ni, .en_i(rx_en_i), .vld_i(rx_bit_vld_i), .bit_i(rx_bit_i),
    .sfd_hit_i(sfd_hit), .frame_o(frame), .deliver_o(deliver),
    .crc_phase_o(crc_phase), .hdr_err_o(hdr_err)
  );

  rxf_ser_out u_out (
    .clk_i, .rst_ni, .en_i(rx_en_i), .frame_i(frame), .deliver_i(deliver),
    .bit_i(rx_bit_i), .inv_i(clk_inv_i), .data_o(ser_data_o),
    .clk_o(ser_clk_o), .clk_raw_o(clk_raw)
  );

  assign data_rdy_o = frame;

  AST_RISE_ON_SFD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_rdy_o) |-> $past(sfd_hit));  // R2
  AST_NO_CLK_OUTSIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_rdy_o |-> !clk_raw);  // R3
  AST_CRC_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(crc_phase) && $past(crc_phase, 2)) |-> !clk_raw);  // R5
  AST_STANDBY_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !data_rdy_o);  // R8
  AST_HDR_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_err |=> (!data_rdy_o && !clk_raw));  // R7
endmodule

// File: tb/rx_framer_test.sv
`timescale 1ns/1ps
module rx_framer_test;
  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, bit_d = 1'b0, vld = 1'b0, inv = 1'b0;
  logic rxd, rxclk, rdy;
  int   n_chk = 0, n_fail = 0, pulses = 0;
  logic prev_raw = 1'b0;
  logic exp_q[$];
  localparam logic [15:0] SFD = 16'hF3A0;

  always #2.5 clk = ~clk;

  rx_framer uut (
    .clk_i(clk), .rst_ni(rst_n), .rx_en_i(rx_en), .rx_bit_i(bit_d),
    .rx_bit_vld_i(vld), .clk_inv_i(inv), .ser_data_o(rxd),
    .ser_clk_o(rxclk), .data_rdy_o(rdy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pop one expected bit per bit-clock rising edge (normalised polarity)
  always @(negedge clk) begin
    logic raw, e;
    raw = rxclk ^ inv;
    if (rst_n && raw && !prev_raw) begin
      pulses++;
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected bit clock", 1, 0);
      else begin
        e = exp_q.pop_front();
        chk(rxd == e, "R4 data bit", rxd, e);
      end
    end
    prev_raw = raw;
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input bit push);
    idle(3);
    bit_d = b;
    vld   = 1'b1;
    if (push) exp_q.push_back(b);
    @(negedge clk);
    vld = 1'b0;
  endtask

  task automatic send_sfd(input bit expect_hit);
    for (int i = 0; i < 16; i++) begin
      if (i == 15) chk(rdy == 1'b0, "R2 early", rdy, 0);
      send_bit(SFD[i], 1'b0);
    end
    chk(rdy == expect_hit, "R2 rise", rdy, expect_hit);
  endtask

  function automatic logic [15:0] calc_fcs(input logic [31:0] d);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < 32; i++) begin
      logic fb = d[i] ^ c[15];
      c = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return ~c;
  endfunction

  // returns with the envelope state checked; flip injects one wrong CRC bit
  task automatic send_hdr(input logic [7:0] sig, input logic [15:0] len, input bit flip);
    logic [31:0] h;
    logic [15:0] fcs;
    int          snap;
    h   = {len, 8'h00, sig};
    fcs = calc_fcs(h);
    if (!(sig inside {8'h0A, 8'h14, 8'h37, 8'h6E})) begin
      for (int i = 0; i < 7; i++) send_bit(h[i], 1'b1);
      chk(rdy == 1'b1, "R7 before bad signal bit", rdy, 1);
      send_bit(h[7], 1'b0);
      chk(rdy == 1'b0, "R7 abort on signal", rdy, 0);
      idle(3);
      return;
    end
    for (int i = 0; i < 32; i++) send_bit(h[i], 1'b1);
    send_bit(fcs[15], 1'b0);
    snap = pulses;
    for (int i = 1; i < 16; i++) send_bit(fcs[15-i] ^ (flip && i == 5), 1'b0);
    if (flip) chk(rdy == 1'b0, "R6 abort on CRC", rdy, 0);
    else      chk(rdy == 1'b1, "R5 held after CRC", rdy, 1);
    idle(3);
    chk(pulses == snap, "R5 silent CRC window", pulses - snap, 0);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit push);
    for (int i = 0; i < 8; i++) send_bit(b[i], push);
  endtask

  task automatic end_frame();
    idle(3);
    chk(exp_q.size() == 0, "R4 all bits clocked", exp_q.size(), 0);
    rx_en = 1'b0;
    @(negedge clk);
    chk(rdy == 1'b0, "R8 envelope drop", rdy, 0);
    idle(2);
    rx_en = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual 1 expected 0");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    chk(rdy == 1'b0, "R1 ready", rdy, 0);
    chk(rxclk == 1'b0, "R1 clock", rxclk, 0);
    chk(rxd == 1'b0, "R1 data", rxd, 0);

    // R8: standby ignores a complete delimiter and a split one
    send_sfd(1'b0);
    chk(rdy == 1'b0, "R8 standby", rdy, 0);
    for (int i = 0; i < 8; i++) send_bit(SFD[i], 1'b0);
    rx_en = 1'b1;
    for (int i = 8; i < 16; i++) send_bit(SFD[i], 1'b0);
    chk(rdy == 1'b0, "R8 split delimiter", rdy, 0);

    // good frame, rate 0x0A, two payload bytes
    send_byte(8'hFF, 1'b0);
    send_sfd(1'b1);
    send_hdr(8'h0A, 16'h0123, 1'b0);
    send_byte(8'hA5, 1'b1);
    send_byte(8'h3C, 1'b1);
    end_frame();

    // CRC error, then immediate restart without enable toggle
    send_sfd(1'b1);
    send_hdr(8'h14, 16'h00F0, 1'b1);
    send_byte(8'h81, 1'b0);
    chk(rdy == 1'b0, "R6 stays low", rdy, 0);
    send_sfd(1'b1);
    chk(rdy == 1'b1, "R10 restart after CRC abort", rdy, 1);
    send_hdr(8'h6E, 16'hBEEF, 1'b0);
    send_byte(8'h5A, 1'b1);
    end_frame();

    // unsupported signal value, then restart
    send_sfd(1'b1);
    send_hdr(8'h0B, 16'h0001, 1'b0);
    chk(exp_q.size() == 0, "R7 no clock for bad bit", exp_q.size(), 0);
    send_sfd(1'b1);
    chk(rdy == 1'b1, "R10 restart after signal abort", rdy, 1);
    send_hdr(8'h14, 16'h0042, 1'b0);
    end_frame();

    // inverted bit clock
    inv = 1'b1;
    idle(2);
    chk(rxclk == 1'b1, "R9 idle level inverted", rxclk, 1);
    send_sfd(1'b1);
    send_hdr(8'h37, 16'h7777, 1'b0);
    send_byte(8'hC3, 1'b1);
    end_frame();
    chk(rxclk == 1'b1, "R9 idle after frame", rxclk, 1);

    // enable dropped mid-payload: remaining bits unclocked
    inv = 1'b0;
    idle(2);
    send_sfd(1'b1);
    send_hdr(8'h0A, 16'h0002, 1'b0);
    send_bit(1'b1, 1'b1);
    idle(3);
    rx_en = 1'b0;
    @(negedge clk);
    chk(rdy == 1'b0, "R8 mid-payload drop", rdy, 0);
    send_byte(8'hFF, 1'b0);
    idle(4);
    chk(exp_q.size() == 0, "R3 nothing pending", exp_q.size(), 0);
    chk(rxclk == 1'b0, "R3 clock idle", rxclk, 0);
    finish_run();
  end
endmodule